// File: doc/BRIEF.md
# USB Host Controller Register File

This block is the I/O-mapped control and status window of a two-port, frame-based full-speed USB host controller. Software reaches it through a small synchronous bus: a 4-bit word address, two byte enables, 16-bit write data, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. The block holds the command word, event status, interrupt enables, frame counter, frame list base, start-of-frame adjust value, two port control words and a loopback capture byte. It drives control bits to the frame scheduler and to the per-port logic.

The port words are mostly live. Connection, line state and speed come straight from the port inputs. The enable bit shows whether the port is actually enabled, which is not always the last value written. Three kinds of reset end port activity: a self-clearing host reset bit, a held global reset bit and a per-port reset bit. Event bits follow write-one-to-clear rules, and an interrupt output summarises the enabled events. The frame counter and the port words accept only full 16-bit writes. A write that enables only one byte to either of them is dropped and flagged.

Word map (byte offsets): command 00h, status 02h, interrupt enable 04h, frame counter 06h, frame base low 08h, frame base high 0Ah, SOF adjust 0Ch, port 0 at 10h, port 1 at 12h, loopback 18h. Every other word reads zero.

Top module: `usb_hc_regs`

## Requirements
- R1: After rst_n, the registers read as follows: command 0000h, status 0020h, interrupt enable 0000h, frame counter 0000h, frame base 0, SOF adjust 0040h, loopback 0000h. Each port reads 0080h while its inputs are low.
- R2: bus_rdata takes the addressed word at the clock edge where bus_rd is high and holds it otherwise. Unmapped words, including 0Eh, 14h and 16h, read 0000h, and so do unused bits.
- R3: Status bits 4:0 set from one-cycle pulses on sts_evt_i and are cleared by writing 1 with the low byte enabled. When a set and a clear fall in the same cycle, the set wins. Bit 5 reads 1 exactly when the run bit is 0.
- R4: irq_o is high whenever status bit i and enable bit i are both 1, for any i in 0..3.
- R5: The command word has run in bit 0, a 64-byte reclamation limit in bit 7 (0 means 32 bytes) and loopback mode in bit 8. Bits 15:9 read 0. A low-byte write with bit 1 set returns every register to its R1 value at that edge, and bit 1 always reads 0.
- R6: While command bit 2 (global reset) is 1, every port has its enable (bit 2), resume (bit 6) and suspend (bit 12) held at 0, and command bit 4 (forced resume) is held at 0.
- R7: While port bit 9 (port reset) is 1, that port has bits 2, 6 and 12 held at 0.
- R8: Port bit 0 mirrors connection, bits 5:4 mirror line state, bit 8 mirrors low speed and bit 7 reads 1. Enable (bit 2) reads 1 only if it was written 1 while the port was connected. A disconnect clears it.
- R9: Port bit 1 sets on any change of the connection input. Port bit 3 sets on a fault pulse, which also clears enable. Both bits clear when 1 is written to them.
- R10: A write to the frame counter or to a port word with exactly one byte enable is ignored, and wr_err_o is high for the following cycle.
- R11: The frame counter is 11 bits wide. It advances by one on frame_tick_i while run is 1 and wraps from 7FFh to 0. A full write in the same cycle takes priority over the advance.
- R12: Frame base bits 11:0 are always 0. Bits 15:12 and the high word can be written byte by byte, and frame_base_o shows the result.
- R13: The SOF adjust value is 7 bits in the low byte at 0Ch. Written bit 7 is dropped.
- R14: While command bit 8 is 1, lb_valid_i loads lb_data_i into the loopback byte. That byte ignores bus writes and holds its value when bit 8 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_waddr | input | 4 | Word address (byte offset / 2) |
| bus_be | input | 2 | Byte enables |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| wr_err_o | output | 1 | Pulse after a rejected partial write |
| sts_evt_i | input | 5 | Status event pulses |
| frame_tick_i | input | 1 | Frame counter advance pulse |
| port_conn_i | input | 2 | Live connection per port |
| port_line_i | input | 4 | Live line state, two bits per port |
| port_ls_i | input | 2 | Live low-speed device per port |
| port_fault_i | input | 2 | Hardware disable pulse per port |
| port_resume_i | input | 2 | Resume detect pulse per port |
| lb_valid_i | input | 1 | Loopback byte strobe |
| lb_data_i | input | 8 | Loopback byte |
| run_o | output | 1 | Scheduler run |
| max_pkt64_o | output | 1 | Reclamation size is 64 bytes |
| loopback_o | output | 1 | Loopback mode |
| global_rst_o | output | 1 | Global reset held |
| force_resume_o | output | 1 | Forced resume signalling |
| frame_num_o | output | 11 | Frame counter |
| frame_base_o | output | 32 | Frame list base address |
| sof_mod_o | output | 7 | SOF adjust value |
| port_en_o | output | 2 | Port enabled |
| port_rst_o | output | 2 | Port reset held |
| port_susp_o | output | 2 | Port suspended |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the masking effect of the global and per-port resets on the exported port bits;
- loss of enable after a disconnect;
- the frame counter advance, and that a byte-wide write leaves it unchanged;
- the error pulse that follows a rejected write;
- the full return to defaults after a host reset;
- interrupt silence once all enables are cleared.

Other behaviour can only be shown through the bench's scenarios:
- the live read-back composition of the port words;
- the priority of a set over a clear in the same cycle on status bits;
- loopback capture gated by the mode bit;
- byte-wise frame base writes;
- reads of reserved words.

// File: rtl/usb_hc_regs.sv
module usb_hc_regs #(
  parameter int FN_W = 11,
  parameter int SOF_W = 7,
  parameter logic [SOF_W-1:0] SOF_RST = 7'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_waddr,
  input  logic [1:0]       bus_be,
  input  logic [15:0]      bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [15:0]      bus_rdata,
  output logic             wr_err_o,
  input  logic [4:0]       sts_evt_i,
  input  logic             frame_tick_i,
  input  logic [1:0]       port_conn_i,
  input  logic [3:0]       port_line_i,
  input  logic [1:0]       port_ls_i,
  input  logic [1:0]       port_fault_i,
  input  logic [1:0]       port_resume_i,
  input  logic             lb_valid_i,
  input  logic [7:0]       lb_data_i,
  output logic             run_o,
  output logic             max_pkt64_o,
  output logic             loopback_o,
  output logic             global_rst_o,
  output logic             force_resume_o,
  output logic [FN_W-1:0]  frame_num_o,
  output logic [31:0]      frame_base_o,
  output logic [SOF_W-1:0] sof_mod_o,
  output logic [1:0]       port_en_o,
  output logic [1:0]       port_rst_o,
  output logic [1:0]       port_susp_o,
  output logic             irq_o
);
  localparam int NP = 2;
  localparam logic [3:0] A_CMD = 4'd0, A_STS = 4'd1, A_IEN = 4'd2, A_FN = 4'd3,
                         A_FBL = 4'd4, A_FBH = 4'd5, A_SOF = 4'd6, A_P0 = 4'd8,
                         A_LB  = 4'd12;

  logic [8:0]       cmd_q, cmd_n;
  logic [4:0]       sts_q, sts_n;
  logic [3:0]       ien_q, ien_n;
  logic [FN_W-1:0]  fn_q, fn_n;
  logic [31:12]     fb_q, fb_n;
  logic [SOF_W-1:0] sof_q, sof_n;
  logic [7:0]       lb_q, lb_n;
  logic [NP-1:0]    en_q, en_n, ec_q, ec_n, cc_q, cc_n;
  logic [NP-1:0]    rs_q, rs_n, pr_q, pr_n, su_q, su_n, prev_q, wp;
  logic [15:0]      prd [NP];
  logic [15:0]      rd_mux;
  logic             err_n;

  wire wr_full  = bus_wr && (bus_be == 2'b11);
  wire wr_part  = bus_wr && (bus_be == 2'b01 || bus_be == 2'b10);
  wire w_cmd    = bus_wr && (bus_waddr == A_CMD);
  wire hc_reset = w_cmd && bus_be[0] && bus_wdata[1];
  wire word_only = (bus_waddr == A_FN) || (bus_waddr == A_P0) || (bus_waddr == A_P0 + 4'd1);

  always_comb begin
    cmd_n = cmd_q;
    if (w_cmd && bus_be[0]) cmd_n[7:0] = {bus_wdata[7:2], 1'b0, bus_wdata[0]};
    if (w_cmd && bus_be[1]) cmd_n[8] = bus_wdata[8];
    if (cmd_n[2]) cmd_n[4] = 1'b0;

    sts_n = sts_q;
    if (bus_wr && bus_waddr == A_STS && bus_be[0]) sts_n = sts_n & ~bus_wdata[4:0];
    sts_n = sts_n | sts_evt_i;

    ien_n = ien_q;
    if (bus_wr && bus_waddr == A_IEN && bus_be[0]) ien_n = bus_wdata[3:0];

    fn_n = fn_q;
    if (wr_full && bus_waddr == A_FN) fn_n = bus_wdata[FN_W-1:0];
    else if (frame_tick_i && cmd_q[0]) fn_n = fn_q + 1'b1;

    fb_n = fb_q;
    if (bus_wr && bus_waddr == A_FBL && bus_be[1]) fb_n[15:12] = bus_wdata[15:12];
    if (bus_wr && bus_waddr == A_FBH && bus_be[0]) fb_n[23:16] = bus_wdata[7:0];
    if (bus_wr && bus_waddr == A_FBH && bus_be[1]) fb_n[31:24] = bus_wdata[15:8];

    sof_n = sof_q;
    if (bus_wr && bus_waddr == A_SOF && bus_be[0]) sof_n = bus_wdata[SOF_W-1:0];

    lb_n = lb_q;
    if (cmd_q[8] && lb_valid_i) lb_n = lb_data_i;

    for (int i = 0; i < NP; i++) begin
      wp[i] = wr_full && (bus_waddr == A_P0 + 4'(i));
      cc_n[i] = (cc_q[i] & ~(wp[i] & bus_wdata[1])) | (port_conn_i[i] ^ prev_q[i]);
      ec_n[i] = (ec_q[i] & ~(wp[i] & bus_wdata[3])) | port_fault_i[i];
      en_n[i] = wp[i] ? bus_wdata[2]  : en_q[i];
      rs_n[i] = (wp[i] ? bus_wdata[6] : rs_q[i]) | port_resume_i[i];
      pr_n[i] = wp[i] ? bus_wdata[9]  : pr_q[i];
      su_n[i] = wp[i] ? bus_wdata[12] : su_q[i];
      if (port_fault_i[i] || !port_conn_i[i]) en_n[i] = 1'b0;
      if (cmd_n[2] || pr_n[i]) begin
        en_n[i] = 1'b0;
        rs_n[i] = 1'b0;
        su_n[i] = 1'b0;
      end
    end

    if (hc_reset) begin
      cmd_n = '0; sts_n = '0; ien_n = '0; fn_n = '0; fb_n = '0;
      sof_n = SOF_RST; lb_n = '0;
      en_n = '0; ec_n = '0; cc_n = '0; rs_n = '0; pr_n = '0; su_n = '0;
    end

    err_n = wr_part && word_only;
  end

  always_comb begin
    for (int i = 0; i < NP; i++)
      prd[i] = {3'b0, su_q[i], 2'b0, pr_q[i], port_ls_i[i], 1'b1, rs_q[i],
                port_line_i[2*i+1], port_line_i[2*i], ec_q[i], en_q[i], cc_q[i], port_conn_i[i]};
    case (bus_waddr)
      A_CMD:       rd_mux = {7'b0, cmd_q};
      A_STS:       rd_mux = {10'b0, ~cmd_q[0], sts_q};
      A_IEN:       rd_mux = {12'b0, ien_q};
      A_FN:        rd_mux = 16'(fn_q);
      A_FBL:       rd_mux = {fb_q[15:12], 12'b0};
      A_FBH:       rd_mux = fb_q[31:16];
      A_SOF:       rd_mux = 16'(sof_q);
      A_P0:        rd_mux = prd[0];
      A_P0 + 4'd1: rd_mux = prd[1];
      A_LB:        rd_mux = {8'b0, lb_q};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; sts_q <= '0; ien_q <= '0; fn_q <= '0; fb_q <= '0;
      sof_q <= SOF_RST; lb_q <= '0;
      en_q <= '0; ec_q <= '0; cc_q <= '0; rs_q <= '0; pr_q <= '0; su_q <= '0;
      prev_q <= '0; bus_rdata <= '0; wr_err_o <= 1'b0;
    end else begin
      cmd_q <= cmd_n; sts_q <= sts_n; ien_q <= ien_n; fn_q <= fn_n; fb_q <= fb_n;
      sof_q <= sof_n; lb_q <= lb_n;
      en_q <= en_n; ec_q <= ec_n; cc_q <= cc_n; rs_q <= rs_n; pr_q <= pr_n; su_q <= su_n;
      prev_q <= port_conn_i;
      if (bus_rd) bus_rdata <= rd_mux;
      wr_err_o <= err_n;
    end
  end

  assign run_o          = cmd_q[0];
  assign global_rst_o   = cmd_q[2];
  assign force_resume_o = cmd_q[4];
  assign max_pkt64_o    = cmd_q[7];
  assign loopback_o     = cmd_q[8];
  assign frame_num_o    = fn_q;
  assign frame_base_o   = {fb_q, 12'b0};
  assign sof_mod_o      = sof_q;
  assign port_en_o      = en_q;
  assign port_rst_o     = pr_q;
  assign port_susp_o    = su_q;
  assign irq_o          = |(sts_q[3:0] & ien_q);
endmodule

// File: rtl/usb_hc_regs_chk.sv
module usb_hc_regs_chk #(
  parameter int FN_W = 11,
  parameter int SOF_W = 7,
  parameter logic [SOF_W-1:0] SOF_RST = 7'h40
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       bus_waddr,
  input logic [1:0]       bus_be,
  input logic [15:0]      bus_wdata,
  input logic             bus_wr,
  input logic             wr_err_o,
  input logic             frame_tick_i,
  input logic [1:0]       port_conn_i,
  input logic             run_o,
  input logic             global_rst_o,
  input logic             force_resume_o,
  input logic [FN_W-1:0]  frame_num_o,
  input logic [SOF_W-1:0] sof_mod_o,
  input logic [1:0]       port_en_o,
  input logic [1:0]       port_rst_o,
  input logic [1:0]       port_susp_o,
  input logic             irq_o
);
  a_r6_global_masks: assert property (@(posedge clk) disable iff (!rst_n)
    global_rst_o |-> (port_en_o == 2'b00 && port_susp_o == 2'b00 && !force_resume_o));

  a_r7_port0_masked: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst_o[0] |-> (!port_en_o[0] && !port_susp_o[0]));

  a_r7_port1_masked: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst_o[1] |-> (!port_en_o[1] && !port_susp_o[1]));

  a_r8_disconnect0: assert property (@(posedge clk) disable iff (!rst_n)
    !port_conn_i[0] |=> !port_en_o[0]);

  a_r8_disconnect1: assert property (@(posedge clk) disable iff (!rst_n)
    !port_conn_i[1] |=> !port_en_o[1]);

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_err_o) |-> ($past(bus_wr) && $past(bus_be) != 2'b11 && $past(bus_be) != 2'b00));

  a_r10_fn_byte_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_waddr == 4'd3 && (bus_be == 2'b01 || bus_be == 2'b10) && !(frame_tick_i && run_o))
    |=> $stable(frame_num_o));

  a_r11_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick_i && run_o && !bus_wr) |=> frame_num_o == FN_W'($past(frame_num_o) + 1'b1));

  a_r5_host_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_waddr == 4'd0 && bus_be[0] && bus_wdata[1])
    |=> (!run_o && frame_num_o == '0 && port_en_o == 2'b00 && sof_mod_o == SOF_RST && !irq_o));

  a_r4_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_waddr == 4'd2 && bus_be[0] && bus_wdata[3:0] == 4'h0) |=> !irq_o);
endmodule

bind usb_hc_regs usb_hc_regs_chk #(.FN_W(FN_W), .SOF_W(SOF_W), .SOF_RST(SOF_RST)) u_chk (.*);

// File: tb/tb_usb_hc_regs.sv
module tb_usb_hc_regs;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_waddr = 0; logic [1:0] bus_be = 0; logic [15:0] bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0; logic [15:0] bus_rdata; logic wr_err_o;
  logic [4:0] sts_evt_i = 0; logic frame_tick_i = 0;
  logic [1:0] port_conn_i = 0, port_ls_i = 0, port_fault_i = 0, port_resume_i = 0;
  logic [3:0] port_line_i = 0; logic lb_valid_i = 0; logic [7:0] lb_data_i = 0;
  logic run_o, max_pkt64_o, loopback_o, global_rst_o, force_resume_o, irq_o;
  logic [10:0] frame_num_o; logic [31:0] frame_base_o; logic [6:0] sof_mod_o;
  logic [1:0] port_en_o, port_rst_o, port_susp_o;

  usb_hc_regs dut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference model
  bit [8:0] m_cmd; bit [4:0] m_sts; bit [3:0] m_ien; int m_fn; bit [31:0] m_fb;
  int m_sof, m_lb, m_rdata; bit m_err;
  bit m_en[2], m_ec[2], m_cc[2], m_rs[2], m_pr[2], m_su[2], m_prev[2];

  task automatic m_defaults();
    m_cmd = 0; m_sts = 0; m_ien = 0; m_fn = 0; m_fb = 0; m_sof = 'h40; m_lb = 0;
    for (int i = 0; i < 2; i++) begin
      m_en[i] = 0; m_ec[i] = 0; m_cc[i] = 0; m_rs[i] = 0; m_pr[i] = 0; m_su[i] = 0;
    end
  endtask

  function automatic int m_read(int a);
    int i;
    case (a)
      0: return m_cmd;
      1: return m_sts | (m_cmd[0] ? 0 : 'h20);
      2: return m_ien;
      3: return m_fn;
      4: return m_fb & 'hF000;
      5: return m_fb >> 16;
      6: return m_sof;
      8, 9: begin
        i = a - 8;
        return 'h80 | port_conn_i[i] | (m_cc[i] << 1) | (m_en[i] << 2) | (m_ec[i] << 3)
             | (((port_line_i >> (2*i)) & 3) << 4) | (m_rs[i] << 6) | (port_ls_i[i] << 8)
             | (m_pr[i] << 9) | (m_su[i] << 12);
      end
      12: return m_lb;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_defaults(); m_rdata = 0; m_err = 0; m_prev[0] = 0; m_prev[1] = 0;
    end else begin
      int a; bit old_run, old_lp, wfull;
      a = bus_waddr; old_run = m_cmd[0]; old_lp = m_cmd[8];
      wfull = bus_wr && bus_be == 3;
      if (bus_rd) m_rdata = m_read(a);
      m_err = bus_wr && (a == 3 || a == 8 || a == 9) && (bus_be == 1 || bus_be == 2);
      if (bus_wr && a == 0 && bus_be[0] && bus_wdata[1]) begin
        m_defaults();
      end else begin
        if (bus_wr && a == 0 && bus_be[0]) m_cmd[7:0] = bus_wdata[7:0] & 8'hFD;
        if (bus_wr && a == 0 && bus_be[1]) m_cmd[8] = bus_wdata[8];
        if (m_cmd[2]) m_cmd[4] = 0;
        if (bus_wr && a == 1 && bus_be[0]) m_sts = m_sts & ~bus_wdata[4:0];
        m_sts = m_sts | sts_evt_i;
        if (bus_wr && a == 2 && bus_be[0]) m_ien = bus_wdata[3:0];
        if (wfull && a == 3) m_fn = bus_wdata & 'h7FF;
        else if (frame_tick_i && old_run) m_fn = (m_fn + 1) & 'h7FF;
        if (bus_wr && a == 4 && bus_be[1]) m_fb[15:12] = bus_wdata[15:12];
        if (bus_wr && a == 5 && bus_be[0]) m_fb[23:16] = bus_wdata[7:0];
        if (bus_wr && a == 5 && bus_be[1]) m_fb[31:24] = bus_wdata[15:8];
        if (bus_wr && a == 6 && bus_be[0]) m_sof = bus_wdata & 'h7F;
        if (old_lp && lb_valid_i) m_lb = lb_data_i;
        for (int i = 0; i < 2; i++) begin
          bit w;
          w = wfull && a == 8 + i;
          if (w && bus_wdata[1]) m_cc[i] = 0;
          if (port_conn_i[i] != m_prev[i]) m_cc[i] = 1;
          if (w && bus_wdata[3]) m_ec[i] = 0;
          if (port_fault_i[i]) m_ec[i] = 1;
          if (w) begin
            m_en[i] = bus_wdata[2]; m_rs[i] = bus_wdata[6];
            m_pr[i] = bus_wdata[9]; m_su[i] = bus_wdata[12];
          end
          if (port_resume_i[i]) m_rs[i] = 1;
          if (port_fault_i[i] || !port_conn_i[i]) m_en[i] = 0;
          if (m_cmd[2] || m_pr[i]) begin m_en[i] = 0; m_rs[i] = 0; m_su[i] = 0; end
        end
      end
      m_prev[0] = port_conn_i[0]; m_prev[1] = port_conn_i[1];
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bus_rdata, m_rdata, "R2 model read data");
      chk(wr_err_o, m_err, "R10 model error pulse");
      chk(irq_o, |(m_sts[3:0] & m_ien), "R4 model irq");
      chk({loopback_o, max_pkt64_o, run_o}, {m_cmd[8], m_cmd[7], m_cmd[0]}, "R5 model command outputs");
      chk({global_rst_o, force_resume_o}, {m_cmd[2], m_cmd[4]}, "R6 model reset outputs");
      chk(frame_num_o, m_fn, "R11 model frame counter");
      chk(frame_base_o, m_fb, "R12 model frame base");
      chk(sof_mod_o, m_sof, "R13 model SOF adjust");
      chk(port_en_o, {m_en[1], m_en[0]}, "R8 model port enable");
      chk(port_rst_o, {m_pr[1], m_pr[0]}, "R7 model port reset");
      chk(port_susp_o, {m_su[1], m_su[0]}, "R6 model port suspend");
    end
  end

  task automatic wr(input [3:0] a, input [1:0] be, input [15:0] d);
    @(negedge clk); bus_wr = 1; bus_waddr = a; bus_be = be; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_be = 0;
  endtask

  task automatic rd_chk(input [3:0] a, input [15:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_waddr = a;
    @(negedge clk); bus_rd = 0;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic finish_tb();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 defaults
    rd_chk(0, 16'h0000, "R1 command default");
    rd_chk(1, 16'h0020, "R1 status default");
    rd_chk(2, 16'h0000, "R1 enable default");
    rd_chk(3, 16'h0000, "R1 frame default");
    rd_chk(6, 16'h0040, "R1 SOF default");
    rd_chk(8, 16'h0080, "R1 port0 default");
    rd_chk(9, 16'h0080, "R1 port1 default");
    rd_chk(12, 16'h0000, "R1 loopback default");
    // R2 reserved words
    rd_chk(7, 16'h0000, "R2 reserved 0Eh");
    rd_chk(10, 16'h0000, "R2 reserved 14h");
    // R5 command layout
    wr(0, 2'b11, 16'hFF81);
    rd_chk(0, 16'h0181, "R5 command readback");
    chk({loopback_o, max_pkt64_o, run_o}, 3'b111, "R5 command outputs");
    // R3 status
    @(negedge clk); sts_evt_i = 5'b00101; @(negedge clk); sts_evt_i = 0;
    rd_chk(1, 16'h0005, "R3 events set, halted clear");
    wr(1, 2'b01, 16'h0001);
    rd_chk(1, 16'h0004, "R3 write one clears");
    @(negedge clk); bus_wr = 1; bus_waddr = 1; bus_be = 2'b01; bus_wdata = 16'h0004; sts_evt_i = 5'b00100;
    @(negedge clk); bus_wr = 0; bus_be = 0; sts_evt_i = 0;
    rd_chk(1, 16'h0004, "R3 set beats clear");
    // R4 interrupt
    wr(2, 2'b01, 16'h0004);
    chk(irq_o, 1, "R4 irq with enable");
    wr(2, 2'b01, 16'h0000);
    chk(irq_o, 0, "R4 irq masked");
    // R11 frame counter
    @(negedge clk); frame_tick_i = 1; repeat (3) @(negedge clk); frame_tick_i = 0;
    rd_chk(3, 16'h0003, "R11 advance");
    wr(3, 2'b11, 16'h07FF);
    @(negedge clk); frame_tick_i = 1; @(negedge clk); frame_tick_i = 0;
    rd_chk(3, 16'h0000, "R11 wrap");
    // R10 partial write
    wr(3, 2'b01, 16'h0055);
    chk(wr_err_o, 1, "R10 error pulse");
    @(negedge clk); chk(wr_err_o, 0, "R10 error single cycle");
    rd_chk(3, 16'h0000, "R10 frame unchanged");
    wr(8, 2'b10, 16'h1000);
    rd_chk(8, 16'h0080, "R10 port byte write ignored");
    // R8 live port state
    wr(8, 2'b11, 16'h0004);
    rd_chk(8, 16'h0080, "R8 enable needs connection");
    @(negedge clk); port_conn_i[0] = 1;
    rd_chk(8, 16'h0083, "R9 connect change");
    wr(8, 2'b11, 16'h0006);
    rd_chk(8, 16'h0085, "R8 enabled, change cleared");
    @(negedge clk); port_line_i[1:0] = 2'b10; port_ls_i[0] = 1;
    rd_chk(8, 16'h01A5, "R8 live line and speed");
    // R9 fault
    @(negedge clk); port_fault_i[0] = 1; @(negedge clk); port_fault_i[0] = 0;
    rd_chk(8, 16'h01A9, "R9 fault disables");
    wr(8, 2'b11, 16'h0008);
    rd_chk(8, 16'h01A1, "R9 enable change cleared");
    // R7 port reset
    wr(8, 2'b11, 16'h0204);
    rd_chk(8, 16'h03A1, "R7 port reset masks enable");
    chk(port_rst_o, 2'b01, "R7 port reset output");
    wr(8, 2'b11, 16'h1004);
    rd_chk(8, 16'h11A5, "R8 enabled and suspended");
    // R6 global reset
    wr(0, 2'b11, 16'h0195);
    rd_chk(0, 16'h0185, "R6 forced resume held low");
    rd_chk(8, 16'h01A1, "R6 port bits cleared");
    wr(0, 2'b11, 16'h0181);
    // R12 frame base
    wr(4, 2'b11, 16'hFFFF);
    rd_chk(4, 16'hF000, "R12 low bits zero");
    wr(5, 2'b10, 16'hABCD);
    rd_chk(5, 16'hAB00, "R12 high byte only");
    chk(frame_base_o, 32'hAB00F000, "R12 base output");
    // R13 SOF adjust
    wr(6, 2'b01, 16'h00FF);
    rd_chk(6, 16'h007F, "R13 seven bits");
    // R14 loopback
    @(negedge clk); lb_valid_i = 1; lb_data_i = 8'h5A; @(negedge clk); lb_valid_i = 0;
    rd_chk(12, 16'h005A, "R14 capture");
    wr(12, 2'b11, 16'h00FF);
    rd_chk(12, 16'h005A, "R14 read only");
    wr(0, 2'b11, 16'h0001);
    @(negedge clk); lb_valid_i = 1; lb_data_i = 8'h33; @(negedge clk); lb_valid_i = 0;
    rd_chk(12, 16'h005A, "R14 capture off");
    // R5 host reset
    @(negedge clk); sts_evt_i = 5'b00011; @(negedge clk); sts_evt_i = 0;
    wr(0, 2'b01, 16'h0003);
    rd_chk(0, 16'h0000, "R5 host reset command");
    rd_chk(1, 16'h0020, "R5 host reset status");
    rd_chk(6, 16'h0040, "R5 host reset SOF");
    rd_chk(5, 16'h0000, "R5 host reset base");
    rd_chk(8, 16'h01A1, "R5 host reset port live bits");
    rd_chk(12, 16'h0000, "R5 host reset loopback");
    repeat (2) @(negedge clk);
    finish_tb();
  end
endmodule